// File: doc/BRIEF.md
# Dual-Bank GPIO Register Controller

This block gives software control over two banks of sixteen general-purpose pins through one set of 32-bit registers. The lower half of every register belongs to the even bank and the upper half to the odd bank, so one access can touch all 32 pins. A direction register picks, pin by pin, whether the block drives the pad. A latched output-data register supplies the driven level. It can be loaded whole, or changed bit by bit through a set strobe and a clear strobe, so that a single pin can be changed without a read-modify-write. An input-data register shows the real pad levels after they have been synchronised into the clock domain.

The register bus is single-cycle and synchronous. Address, write enable and write data are sampled on the rising clock edge. Read data is a combinational function of the address and the current register state, so it is valid in the same cycle the address is presented. A write becomes visible on the outputs and in the read data one cycle later. Reset is synchronous and active low.

Top module: `gpio_pair_ctrl`

## Requirements
- R1: After reset every direction bit is 1 (all pins inputs), the output-data register is 0, `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: A write at address 0 loads the direction register. In the next cycle `pin_oe[i]` equals the inverse of direction bit i (0 = drive, 1 = input). Reading address 0 returns the direction register.
- R3: A write at address 1 loads the output-data register with `wr_data`. From the next cycle `pin_out` shows that value.
- R4: A write at address 2 forces to 1 every output-data bit where `wr_data` is 1 and leaves the bits where `wr_data` is 0 unchanged.
- R5: A write at address 3 forces to 0 every output-data bit where `wr_data` is 1 and leaves the bits where `wr_data` is 0 unchanged.
- R6: Reads at addresses 1, 2 and 3 all return the latched output-data register, including bits whose pins are set as inputs. `pin_out` carries the latched value whatever the direction bit is.
- R7: A read at address 4 returns the level that `pin_in` had at the rising edge two edges before the most recent one: two synchroniser stages and one capture register.
- R8: Pin n (0..15) of the even bank maps to bit n of every register and port, and pin n of the odd bank maps to bit 16+n.
- R9: Writes to addresses 5 to 7 change no state, and reads there return 0.
- R10: With no write enabled, `pin_out` and `pin_oe` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register word address |
| wr_en | input | 1 | Write strobe for the addressed register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, valid in the same cycle |
| pin_out | output | 32 | Driven level for each pin |
| pin_oe | output | 32 | Output enable for each pin, 1 = drive |
| pin_in | input | 32 | Raw pad level for each pin |

## Verification
The assertions check on every cycle that `pin_oe` follows the last direction write inverted, that each kind of output write updates `pin_out` by its own rule, that the outputs hold with no write, that addresses 1 to 3 read back `pin_out`, that the input register lags the pads by exactly three edges, and that unmapped reads return 0. Only the bench's scenarios can show the reset values, the bit mapping of the two banks onto the halves of the word, that writes to unmapped addresses leave the state untouched, and that the set and clear strobes do not disturb their neighbouring bits when several patterns follow one another.

// File: rtl/gpio_pair_pkg.sv
// Package: shared register selector for the dual-bank GPIO controller.
// Assumes a 3-bit word address. Codes 5..7 are unmapped.
package gpio_pair_pkg;

    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        SEL_DIR = 3'd0,
        SEL_OUT = 3'd1,
        SEL_SET = 3'd2,
        SEL_CLR = 3'd3,
        SEL_IN  = 3'd4
    } reg_sel_e;

endpackage

// File: rtl/gpio_bank_regs.sv
// Module: direction and output-data state for one bank of pins.
// Assumes at most one of the write strobes is active in a cycle.
// The priority order set > clear > load only matters if that ever changes.
module gpio_bank_regs #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_dir,
    input  logic         wr_load,
    input  logic         wr_set,
    input  logic         wr_clr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] out_q
);

    // Direction state: reset to all inputs, loaded whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= '1;
        end else if (wr_dir) begin
            dir_q <= wdata;
        end
    end

    // Output latch: bitwise set or clear by mask, or loaded whole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else if (wr_set) begin
            out_q <= out_q | wdata;
        end else if (wr_clr) begin
            out_q <= out_q & ~wdata;
        end else if (wr_load) begin
            out_q <= wdata;
        end
    end

endmodule

// File: rtl/gpio_pin_sync.sv
// Module: multi-stage synchroniser followed by a capture register for pin inputs.
// Assumes STAGES >= 1. The total latency from the pin to q is STAGES+1 edges.
module gpio_pin_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    // First stage samples the asynchronous pad level.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Further stages settle any metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    // Capture register read by software.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= chain[STAGES-1];
    end

endmodule

// File: rtl/gpio_pair_ctrl.sv
// Module: dual-bank GPIO register controller (top).
// Bank b owns bits [b*BANK_W +: BANK_W] of every register and port.
// Read data is combinational from addr. Writes take effect on the next edge.
module gpio_pair_ctrl
    import gpio_pair_pkg::*;
#(
    parameter int BANK_W      = 16,
    parameter int NUM_BANKS   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              addr,
    input  logic                           wr_en,
    input  logic [BANK_W*NUM_BANKS-1:0]    wr_data,
    output logic [BANK_W*NUM_BANKS-1:0]    rd_data,
    output logic [BANK_W*NUM_BANKS-1:0]    pin_out,
    output logic [BANK_W*NUM_BANKS-1:0]    pin_oe,
    input  logic [BANK_W*NUM_BANKS-1:0]    pin_in
);

    localparam int DATA_W = BANK_W * NUM_BANKS;

    logic              wr_dir, wr_load, wr_set, wr_clr;
    logic [DATA_W-1:0] dir_all, out_all, in_all;

    // Decode the write strobe into one strobe per register.
    always_comb begin
        wr_dir  = wr_en && (addr == SEL_DIR);
        wr_load = wr_en && (addr == SEL_OUT);
        wr_set  = wr_en && (addr == SEL_SET);
        wr_clr  = wr_en && (addr == SEL_CLR);
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        gpio_bank_regs #(.W(BANK_W)) u_regs (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_dir  (wr_dir),
            .wr_load (wr_load),
            .wr_set  (wr_set),
            .wr_clr  (wr_clr),
            .wdata   (wr_data[b*BANK_W +: BANK_W]),
            .dir_q   (dir_all[b*BANK_W +: BANK_W]),
            .out_q   (out_all[b*BANK_W +: BANK_W])
        );

        gpio_pin_sync #(.W(BANK_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pin_in[b*BANK_W +: BANK_W]),
            .q     (in_all[b*BANK_W +: BANK_W])
        );
    end

    // Pad drive: the latched level always, the enable from direction inverted.
    always_comb begin
        pin_out = out_all;
        pin_oe  = ~dir_all;
    end

    // Read mux: the three output views share the latch, unmapped reads give 0.
    always_comb begin
        case (addr)
            SEL_DIR:                   rd_data = dir_all;
            SEL_OUT, SEL_SET, SEL_CLR: rd_data = out_all;
            SEL_IN:                    rd_data = in_all;
            default:                   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_pair_chk.sv
// Module: property checker for gpio_pair_ctrl, attached by bind.
// Assumes the same port widths as the top. LAT is the pin-to-register latency.
module gpio_pair_chk #(
    parameter int DATA_W = 32,
    parameter int LAT    = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        addr,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic [DATA_W-1:0] rd_data,
    input logic [DATA_W-1:0] pin_out,
    input logic [DATA_W-1:0] pin_oe,
    input logic [DATA_W-1:0] pin_in
);

    logic              armed;
    logic [DATA_W-1:0] hist [LAT];

    // Arm the properties one edge after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Delay line of pad levels, used to check the input latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) hist[i] <= '0;
        end else begin
            hist[0] <= pin_in;
            for (int i = 1; i < LAT; i++) hist[i] <= hist[i-1];
        end
    end

    p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(wr_en && addr == 3'd0) |-> pin_oe == ~$past(wr_data));

    p_load_out_r3: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(wr_en && addr == 3'd1) |-> pin_out == $past(wr_data));

    p_set_mask_r4: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(wr_en && addr == 3'd2) |-> pin_out == ($past(pin_out) | $past(wr_data)));

    p_clr_mask_r5: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        $past(wr_en && addr == 3'd3) |-> pin_out == ($past(pin_out) & ~$past(wr_data)));

    p_mirror_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd1 || addr == 3'd2 || addr == 3'd3) |-> rd_data == pin_out);

    p_in_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == 3'd4) |-> rd_data == hist[LAT-1]);

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (addr > 3'd4) |-> rd_data == '0);

    p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        !$past(wr_en) |-> ($stable(pin_out) && $stable(pin_oe)));

endmodule

bind gpio_pair_ctrl gpio_pair_chk #(
    .DATA_W (BANK_W * NUM_BANKS),
    .LAT    (SYNC_STAGES + 1)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_data (rd_data),
    .pin_out (pin_out),
    .pin_oe  (pin_oe),
    .pin_in  (pin_in)
);

// File: tb/gpio_pair_ctrl_test.sv
// Bench: a behavioural reference model compared with the outputs on every clock,
// plus directed checks for each requirement.
module gpio_pair_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] pin_in = '0;
    logic [31:0] rd_data, pin_out, pin_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Reference state
    logic [31:0] m_dir = '1;
    logic [31:0] m_out = '0;
    logic [31:0] m_pins [$] = '{32'd0, 32'd0, 32'd0};

    always #10 clk = ~clk;   // 50 MHz

    gpio_pair_ctrl uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .pin_in(pin_in)
    );

    task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [2:0] a);
        case (a)
            3'd0:             return m_dir;
            3'd1, 3'd2, 3'd3: return m_out;
            3'd4:             return m_pins[0];
            default:          return 32'd0;
        endcase
    endfunction

    // Reference update at each rising edge from the stable inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_dir = '1;
            m_out = '0;
            m_pins = '{32'd0, 32'd0, 32'd0};
        end else begin
            if (wr_en) begin
                case (addr)
                    3'd0: m_dir = wr_data;
                    3'd1: m_out = wr_data;
                    3'd2: m_out = m_out | wr_data;
                    3'd3: m_out = m_out & ~wr_data;
                    default: ;
                endcase
            end
            m_pins.push_back(pin_in);
            if (m_pins.size() > 3) void'(m_pins.pop_front());
        end
    end

    // Every-cycle comparison, 8 ns after the edge, before the inputs move.
    always @(posedge clk) begin
        #8;
        if (rst_n && !done) begin
            cmp("R2 oe", pin_oe, ~m_dir);
            cmp("R3 out", pin_out, m_out);
            case (addr)
                3'd0:             cmp("R2 read", rd_data, exp_read(addr));
                3'd1, 3'd2, 3'd3: cmp("R6 read", rd_data, exp_read(addr));
                3'd4:             cmp("R7 read", rd_data, exp_read(addr));
                default:          cmp("R9 read", rd_data, exp_read(addr));
            endcase
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, input string req, input logic [31:0] exp);
        @(negedge clk);
        addr = a;
        #2;
        cmp(req, rd_data, exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        cmp("R1 oe", pin_oe, 32'h0);
        cmp("R1 out", pin_out, 32'h0);
        rd(3'd0, "R1 dir", 32'hFFFF_FFFF);
        rst_n = 1'b1;

        // R2: even bank to outputs
        wr(3'd0, 32'hFFFF_0000);
        #2 cmp("R2 oe", pin_oe, 32'h0000_FFFF);
        // R4: set by mask
        wr(3'd2, 32'h0000_00A5);
        #2 cmp("R4 set", pin_out, 32'h0000_00A5);
        wr(3'd2, 32'h0000_0300);
        #2 cmp("R4 set keep", pin_out, 32'h0000_03A5);
        // R5: clear by mask
        wr(3'd3, 32'h0000_0105);
        #2 cmp("R5 clr", pin_out, 32'h0000_02A0);
        // R3: direct load
        wr(3'd1, 32'h1234_5678);
        #2 cmp("R3 load", pin_out, 32'h1234_5678);
        // R6: mirror reads, including upper pins configured as inputs
        rd(3'd2, "R6 set view", 32'h1234_5678);
        rd(3'd3, "R6 clr view", 32'h1234_5678);
        rd(3'd1, "R6 out view", 32'h1234_5678);
        // R8: odd-bank pin 5 is bit 21
        wr(3'd1, 32'h0);
        wr(3'd2, 32'h0020_0000);
        #2 cmp("R8 odd bank", pin_out, 32'h0020_0000);
        wr(3'd0, 32'h0000_FFFF);
        #2 cmp("R8 odd oe", pin_oe, 32'hFFFF_0000);
        // R9: unmapped writes ignored, reads zero
        wr(3'd5, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0);
        #2 cmp("R9 out kept", pin_out, 32'h0020_0000);
        cmp("R9 oe kept", pin_oe, 32'hFFFF_0000);
        rd(3'd6, "R9 read", 32'h0);
        // R7: input latency of three edges
        rd(3'd4, "R7 idle", 32'h0);
        @(negedge clk); pin_in = 32'hC0DE_BEEF;
        @(negedge clk); #2 cmp("R7 edge1", rd_data, 32'h0);
        @(negedge clk); #2 cmp("R7 edge2", rd_data, 32'h0);
        @(negedge clk); #2 cmp("R7 edge3", rd_data, 32'hC0DE_BEEF);
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); pin_in = {pin_in[30:0], pin_in[31] ^ pin_in[21]};
        end
        // R10: idle cycles keep outputs
        repeat (5) @(negedge clk);
        #2 cmp("R10 hold", pin_out, 32'h0020_0000);
        // R4 and R5 across both banks in sequence
        wr(3'd2, 32'h8001_8001);
        wr(3'd3, 32'h0001_0000);
        #2 cmp("R5 after R4", pin_out, 32'h8020_8001);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule